// File: doc/BRIEF.md
# Addressed Serial Register Port

This block is the serial slave through which an external master reaches the small register map of an analog front end. The master lowers chip select, clocks in one control byte and then moves any number of data bytes. The control byte carries a two-bit device address, a five-bit register address and a direction flag. The device address lets several such slaves share one set of bus wires. The serial pins are oversampled by the system clock, so the serial clock must be slower than about a quarter of the system clock.

Writes go to the addressed register and then step through the map, wrapping at its end. Reads return the addressed register first. Each later address comes from a read-mode field held in a communication register. That field can repeat one register or cycle through an aligned group, through one register kind (data or configuration), or through the whole map. A parallel port shows every register at once. A hardware update port lets the conversion side load the data registers, which the serial side cannot write.

Top module: `spi_afe_if`

## Requirements
- R1: Bits are taken on the rising serial-clock edge and the data output changes on the falling edge. Both the low-idle clock (mode 0) and the high-idle clock (mode 3) work, MSB first.
- R2: The first byte after chip select falls is the control byte. Bits [7:6] are the device address, bits [5:1] the register address and bit [0] the direction, where 1 means read and 0 means write.
- R3: The device address of this slave is fixed at 2'b00. A transaction with any other device address changes no register and keeps the output disabled.
- R4: In a write, each complete data byte goes to the current address, which then advances by one. After the last map entry (NUM_REGS-1) the address goes back to 0.
- R5: Addresses 0 to DATA_REGS-1 are data registers, and serial writes to them are dropped. The write address still advances past them.
- R6: Serial writes at an undefined address (NUM_REGS or above) change nothing, and the address counter stays frozen for the rest of the transaction.
- R7: A read that starts at an undefined address returns 8'h00 for every byte.
- R8: sdo_en_o is low while chip select is high, during the control byte, and for the whole of a write or of an ignored transaction. It is high for the data bytes of a read.
- R9: During a read, bits [7:6] of register COM_ADDR (default 10) pick the next address after each byte. 0 repeats the same register. 1 cycles inside the aligned group of GROUP registers (clipped to the map). 2 cycles inside the current kind, data 0..DATA_REGS-1 or configuration DATA_REGS..NUM_REGS-1. 3 cycles through the whole map.
- R10: Chip select going high at any time clears the bit count and the control state. A partly shifted byte is discarded and writes nothing.
- R11: All registers reset to 8'h00. A hardware update writes any defined address, takes priority over a serial write in the same cycle, and regs_o shows register i at bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from the master |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |
| sdo_en_o | output | 1 | Output-driver enable for sdo_o; low means high impedance |
| hw_we_i | input | 1 | Hardware update strobe |
| hw_addr_i | input | 5 | Hardware update address |
| hw_wdata_i | input | 8 | Hardware update data |
| regs_o | output | NUM_REGS*8 | Parallel view of all registers |

## Verification
The assertions assume that the serial clock, data and chip select change slowly against the system clock. Each level must last for several system cycles so that the synchronised edges arrive in order, and data must be stable around every rising serial edge. The assertions also assume that the hardware update port only drives defined addresses. The stimulus holds every serial level for eight system clocks and changes data only at falling serial edges or while the slave is deselected. Register contents are compared against a behavioural model on every idle clock.

// File: rtl/spi_afe_pkg.sv
package spi_afe_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {PH_CTRL, PH_WRITE, PH_READ, PH_SKIP} phase_e;
  typedef enum logic [1:0] {RM_HOLD, RM_GROUP, RM_KIND, RM_ALL} rdmode_e;

  typedef struct packed {
    logic [1:0]        dev;
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } ctrl_t;
endpackage

// File: rtl/spi_afe_sync.sv
module spi_afe_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {(STAGES+1){RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-1:0], d_i[g]};
    end
    assign q_o[g]      = chain_q[STAGES-1];
    assign q_prev_o[g] = chain_q[STAGES];
  end
endmodule

// File: rtl/spi_afe_frame.sv
module spi_afe_frame
  import spi_afe_pkg::*;
#(
  parameter logic [1:0] DEV_ADDR = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output phase_e            phase_o,
  output logic [2:0]        bit_cnt_o,
  output logic              ctrl_v_o,
  output ctrl_t             ctrl_o,
  output logic              byte_v_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-2:0] sh_q;
  logic [2:0]        cnt_q;
  phase_e            ph_q;
  logic [BYTE_W-1:0] full;
  logic              last_bit;

  assign full     = {sh_q, sdi_i};
  assign last_bit = sel_i && rise_i && (cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ph_q  <= PH_CTRL;
    end else if (!sel_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ph_q  <= PH_CTRL;
    end else if (rise_i) begin
      sh_q  <= full[BYTE_W-2:0];
      cnt_q <= cnt_q + 3'd1;
      if (cnt_q == 3'd7 && ph_q == PH_CTRL) begin
        if (full[7:6] != DEV_ADDR) ph_q <= PH_SKIP;
        else if (full[0])          ph_q <= PH_READ;
        else                       ph_q <= PH_WRITE;
      end
    end
  end

  assign phase_o   = ph_q;
  assign bit_cnt_o = cnt_q;
  assign ctrl_v_o  = last_bit && (ph_q == PH_CTRL);
  assign ctrl_o    = ctrl_t'(full);
  assign byte_v_o  = last_bit && (ph_q == PH_WRITE || ph_q == PH_READ);
  assign byte_o    = full;
endmodule

// File: rtl/spi_afe_addr_seq.sv
module spi_afe_addr_seq
  import spi_afe_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int DATA_REGS = 6,
  parameter int GROUP     = 4
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  rdmode_e           mode_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              defined_o
);
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(NUM_REGS - 1);
  localparam logic [ADDR_W-1:0] DLAST  = ADDR_W'(DATA_REGS - 1);
  localparam logic [ADDR_W-1:0] DFIRST = ADDR_W'(DATA_REGS);
  localparam logic [ADDR_W-1:0] GMASK  = ~ADDR_W'(GROUP - 1);

  logic [ADDR_W-1:0] inc, g_lo, g_hi, step;
  logic [ADDR_W:0]   g_top;

  always_comb begin
    defined_o = ({1'b0, cur_i} < (ADDR_W+1)'(NUM_REGS));
    inc       = cur_i + 1'b1;
    g_lo      = cur_i & GMASK;
    g_top     = {1'b0, g_lo} + (ADDR_W+1)'(GROUP - 1);
    g_hi      = (g_top > (ADDR_W+1)'(NUM_REGS - 1)) ? LAST : g_top[ADDR_W-1:0];
    unique case (mode_i)
      RM_HOLD:  step = cur_i;
      RM_GROUP: step = (cur_i == g_hi) ? g_lo : inc;
      RM_KIND:  if (cur_i < DFIRST) step = (cur_i == DLAST) ? '0 : inc;
                else                step = (cur_i == LAST) ? DFIRST : inc;
      default:  step = (cur_i == LAST) ? '0 : inc;
    endcase
    nxt_o = defined_o ? step : cur_i;
  end
endmodule

// File: rtl/spi_afe_regfile.sv
module spi_afe_regfile
  import spi_afe_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int DATA_REGS = 6,
  parameter int COM_ADDR  = 10,
  parameter int MODE_LSB  = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     spi_we_i,
  input  logic [ADDR_W-1:0]        spi_addr_i,
  input  logic [BYTE_W-1:0]        spi_wdata_i,
  input  logic                     hw_we_i,
  input  logic [ADDR_W-1:0]        hw_addr_i,
  input  logic [BYTE_W-1:0]        hw_wdata_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [BYTE_W-1:0]        rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output rdmode_e                  mode_o
);
  logic [BYTE_W-1:0] arr [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hw_hit, spi_hit;
    assign hw_hit = hw_we_i && (hw_addr_i == ADDR_W'(i));
    if (i >= DATA_REGS) begin : g_rw
      assign spi_hit = spi_we_i && (spi_addr_i == ADDR_W'(i));
    end else begin : g_ro
      assign spi_hit = 1'b0;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      arr[i] <= '0;
      else if (hw_hit)  arr[i] <= hw_wdata_i;
      else if (spi_hit) arr[i] <= spi_wdata_i;
    end
    assign regs_o[i*BYTE_W +: BYTE_W] = arr[i];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr_i == ADDR_W'(i)) rd_data_o = arr[i];
  end

  assign mode_o = rdmode_e'(arr[COM_ADDR][MODE_LSB +: 2]);
endmodule

// File: rtl/spi_afe_if.sv
module spi_afe_if
  import spi_afe_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         DATA_REGS   = 6,
  parameter int         GROUP       = 4,
  parameter int         COM_ADDR    = 10,
  parameter int         MODE_LSB    = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [1:0] DEV_ADDR    = 2'b00
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cs_ni,
  input  logic                        sck_i,
  input  logic                        sdi_i,
  output logic                        sdo_o,
  output logic                        sdo_en_o,
  input  logic                        hw_we_i,
  input  logic [4:0]                  hw_addr_i,
  input  logic [7:0]                  hw_wdata_i,
  output logic [NUM_REGS*BYTE_W-1:0]  regs_o
);
  logic [2:0] pin_s, pin_d;
  logic       sel, rise, fall;

  spi_afe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i      ({cs_ni, sck_i, sdi_i}),
    .q_o      (pin_s),
    .q_prev_o (pin_d)
  );

  assign sel  = ~pin_s[2];
  assign rise = pin_s[1] & ~pin_d[1];
  assign fall = ~pin_s[1] & pin_d[1];

  phase_e            phase;
  logic [2:0]        bit_cnt;
  logic              ctrl_v, byte_v;
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] rx_byte;

  spi_afe_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
    .clk_i, .rst_ni,
    .sel_i     (sel),
    .rise_i    (rise),
    .sdi_i     (pin_s[0]),
    .phase_o   (phase),
    .bit_cnt_o (bit_cnt),
    .ctrl_v_o  (ctrl_v),
    .ctrl_o    (ctrl),
    .byte_v_o  (byte_v),
    .byte_o    (rx_byte)
  );

  logic [ADDR_W-1:0] ptr_q, nxt, rd_addr;
  logic              defined;
  rdmode_e           com_mode, seq_mode;

  // writes always walk the whole map; reads follow the mode field
  assign seq_mode = (phase == PH_WRITE) ? RM_ALL : com_mode;

  spi_afe_addr_seq #(.NUM_REGS(NUM_REGS), .DATA_REGS(DATA_REGS), .GROUP(GROUP)) u_seq (
    .cur_i     (ptr_q),
    .mode_i    (seq_mode),
    .nxt_o     (nxt),
    .defined_o (defined)
  );

  logic              spi_we;
  logic [BYTE_W-1:0] rd_data;

  assign spi_we  = byte_v && (phase == PH_WRITE) && defined;
  assign rd_addr = ctrl_v ? ctrl.addr : nxt;

  spi_afe_regfile #(
    .NUM_REGS(NUM_REGS), .DATA_REGS(DATA_REGS), .COM_ADDR(COM_ADDR), .MODE_LSB(MODE_LSB)
  ) u_regs (
    .clk_i, .rst_ni,
    .spi_we_i    (spi_we),
    .spi_addr_i  (ptr_q),
    .spi_wdata_i (rx_byte),
    .hw_we_i,
    .hw_addr_i,
    .hw_wdata_i,
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .regs_o,
    .mode_o      (com_mode)
  );

  logic [BYTE_W-1:0] tx_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ctrl_v) ptr_q <= ctrl.addr;
    else if (byte_v) ptr_q <= nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tx_q <= '0;
    else if (ctrl_v && ctrl.rd)           tx_q <= rd_data;
    else if (byte_v && phase == PH_READ)  tx_q <= rd_data;
  end

  // bit index of the byte in flight is 7 - bit_cnt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       sdo_q <= 1'b0;
    else if (!sel)                     sdo_q <= 1'b0;
    else if (fall && phase == PH_READ) sdo_q <= tx_q[~bit_cnt];
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = sel && (phase == PH_READ);
endmodule

// File: rtl/spi_afe_if_chk.sv
module spi_afe_if_chk
  import spi_afe_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int DATA_REGS = 6
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        sel_i,
  input phase_e                      phase_i,
  input logic                        sdo_en_i,
  input logic                        spi_we_i,
  input logic [ADDR_W-1:0]           ptr_i,
  input logic [2:0]                  bit_cnt_i,
  input logic [BYTE_W-1:0]           tx_i,
  input logic [DATA_REGS*BYTE_W-1:0] data_regs_i,
  input logic                        hw_we_i
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

  p_hiz_deselected_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> !sdo_en_i);

  p_hiz_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_WRITE || phase_i == PH_SKIP) |-> !sdo_en_i);

  p_no_foreign_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_WRITE) |-> !spi_we_i);

  p_write_defined_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_we_i |-> ({1'b0, ptr_i} < (ADDR_W+1)'(NUM_REGS)));

  p_write_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_we_i |=> (ptr_i == (($past(ptr_i) == LAST) ? '0 : $past(ptr_i) + 1'b1)));

  p_undef_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && phase_i == PH_WRITE && {1'b0, ptr_i} >= (ADDR_W+1)'(NUM_REGS)) |=> $stable(ptr_i));

  p_data_regs_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_we_i |=> $stable(data_regs_i));

  p_bit_cnt_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> (bit_cnt_i == 3'd0));

  p_undef_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && phase_i == PH_READ && {1'b0, ptr_i} >= (ADDR_W+1)'(NUM_REGS)) |-> (tx_i == '0));
endmodule

bind spi_afe_if spi_afe_if_chk #(.NUM_REGS(NUM_REGS), .DATA_REGS(DATA_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel),
  .phase_i     (phase),
  .sdo_en_i    (sdo_en_o),
  .spi_we_i    (spi_we),
  .ptr_i       (ptr_q),
  .bit_cnt_i   (bit_cnt),
  .tx_i        (tx_q),
  .data_regs_i (regs_o[DATA_REGS*8-1:0]),
  .hw_we_i     (hw_we_i)
);

// File: tb/spi_afe_if_tb_top.sv
module spi_afe_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NUM        = 16;
  localparam int DATA       = 6;
  localparam int GRP        = 4;
  localparam int COM        = 10;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic hw_we = 1'b0;
  logic [4:0] hw_addr = '0;
  logic [7:0] hw_wdata = '0;
  logic [NUM*8-1:0] regs;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_afe_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .hw_we_i(hw_we), .hw_addr_i(hw_addr),
    .hw_wdata_i(hw_wdata), .regs_o(regs)
  );

  logic [7:0] mdl [NUM];
  int  n_tests = 0, n_fail = 0;
  bit  mon_on = 1'b0, done = 1'b0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock comparison against the model while the bus is idle
  always @(negedge clk) begin
    if (mon_on && rst_n && cs_n) begin
      for (int i = 0; i < NUM; i++)
        check(regs[i*8 +: 8] === mdl[i], "R11", $sformatf("idle reg %0d", i), regs[i*8 +: 8], mdl[i]);
      check(sdo_en === 1'b0, "R8", "idle output enable", sdo_en, 0);
    end
  end

  task automatic chk_regs(string req);
    bit ok = 1'b1;
    int bad = -1;
    for (int i = 0; i < NUM; i++)
      if (regs[i*8 +: 8] !== mdl[i] && bad < 0) begin ok = 1'b0; bad = i; end
    if (bad < 0) bad = 0;
    check(ok, req, $sformatf("register map, reg %0d", bad), regs[bad*8 +: 8], mdl[bad]);
  endtask

  task automatic spi_xfer(input bit cpol, input bq_t tx, input int nbits, input bit exp_en,
                          output bq_t rx, output int en_bad);
    logic [7:0] cur = '0;
    rx = {};
    en_bad = 0;
    mon_on = 1'b0;
    @(negedge clk);
    sck = cpol;
    wait_clk(HALF);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int b = 0; b < nbits; b++) begin
      sck = 1'b0;
      sdi = tx[b/8][7-(b%8)];
      wait_clk(HALF);
      if (b < 8) begin
        if (sdo_en !== 1'b0) en_bad++;
      end else begin
        if (sdo_en !== exp_en) en_bad++;
        cur = {cur[6:0], sdo};
        if (b % 8 == 7) rx.push_back(cur);
      end
      sck = 1'b1;
      wait_clk(HALF);
    end
    if (!cpol) begin sck = 1'b0; wait_clk(HALF); end
    cs_n = 1'b1;
    sdi  = 1'b0;
    wait_clk(2*HALF);
    mon_on = 1'b1;
  endtask

  task automatic do_wr(bit cpol, logic [1:0] dev, logic [4:0] a, bq_t d, string req);
    bq_t tx, rx;
    int bad;
    int p = a;
    tx.push_back({dev, a, 1'b0});
    foreach (d[i]) tx.push_back(d[i]);
    spi_xfer(cpol, tx, tx.size()*8, 1'b0, rx, bad);
    check(bad == 0, {req, " R8"}, "output enable during write", bad, 0);
    if (dev == 2'b00)
      foreach (d[i]) begin
        if (p >= NUM) break;
        if (p >= DATA) mdl[p] = d[i];
        p = (p + 1) % NUM;
      end
    chk_regs(req);
  endtask

  function automatic int nxt_addr(int a, int mode);
    int lo, hi;
    case (mode)
      0: return a;
      1: begin
        lo = (a / GRP) * GRP;
        hi = (lo + GRP - 1 > NUM - 1) ? NUM - 1 : lo + GRP - 1;
        return (a == hi) ? lo : a + 1;
      end
      2: if (a < DATA) return (a == DATA - 1) ? 0 : a + 1;
         else          return (a == NUM - 1) ? DATA : a + 1;
      default: return (a + 1) % NUM;
    endcase
  endfunction

  task automatic do_rd(bit cpol, logic [1:0] dev, logic [4:0] a, int n, string req);
    bq_t tx, rx;
    int bad;
    int p = a;
    int mode = mdl[COM][7:6];
    logic [7:0] exp;
    tx.push_back({dev, a, 1'b1});
    for (int i = 0; i < n; i++) tx.push_back(8'h00);
    spi_xfer(cpol, tx, tx.size()*8, dev == 2'b00, rx, bad);
    check(bad == 0, {req, " R8"}, "output enable during read", bad, 0);
    if (dev == 2'b00)
      for (int i = 0; i < n; i++) begin
        exp = (p < NUM) ? mdl[p] : 8'h00;
        check(rx[i] === exp, req, $sformatf("read byte %0d", i), rx[i], exp);
        if (p < NUM) p = nxt_addr(p, mode);
      end
    chk_regs(req);
  endtask

  task automatic hw_wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    hw_we = 1'b1; hw_addr = a; hw_wdata = d;
    @(negedge clk);
    hw_we = 1'b0;
    mdl[a] = d;
  endtask

  initial begin
    bq_t rx;
    int bad;
    for (int i = 0; i < NUM; i++) mdl[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    chk_regs("R11 reset");
    check(sdo_en === 1'b0, "R8", "enable after reset", sdo_en, 0);
    mon_on = 1'b1;

    for (int i = 0; i < DATA; i++) hw_wr(5'(i), 8'(8'hA0 + 8'h11 * i));
    hw_wr(5'd12, 8'h3C);
    wait_clk(2);
    chk_regs("R11 hw port");

    do_wr(1'b0, 2'b00, 5'd6, '{8'h11, 8'h22, 8'h33}, "R1 R2 R4");
    do_wr(1'b1, 2'b00, 5'd14, '{8'h44, 8'h55, 8'h66, 8'h77, 8'h88}, "R1 R4 R5 wrap");
    do_wr(1'b0, 2'b00, 5'd4, '{8'h99, 8'hAA, 8'hBB}, "R5");
    do_wr(1'b0, 2'b00, 5'd20, '{8'hCC, 8'hDD}, "R6");
    do_wr(1'b1, 2'b00, 5'd31, '{8'hEE, 8'hEF}, "R6 top");
    do_wr(1'b0, 2'b01, 5'd7, '{8'h5A}, "R3 write");
    do_rd(1'b0, 2'b10, 5'd0, 2, "R3 read");

    // partial data byte, then partial control byte
    spi_xfer(1'b0, '{{2'b00, 5'd8, 1'b0}, 8'hFF}, 13, 1'b0, rx, bad);
    chk_regs("R10 partial data");
    spi_xfer(1'b1, '{{2'b00, 5'd9, 1'b0}}, 4, 1'b0, rx, bad);
    chk_regs("R10 partial ctrl");
    do_wr(1'b0, 2'b00, 5'd8, '{8'hC3}, "R10 recovery");

    do_wr(1'b0, 2'b00, 5'(COM), '{8'h00}, "R9 set hold");
    do_rd(1'b0, 2'b00, 5'd3, 3, "R9 hold");
    do_wr(1'b0, 2'b00, 5'(COM), '{8'h45}, "R9 set group");
    do_rd(1'b1, 2'b00, 5'd5, 5, "R9 group");
    do_rd(1'b0, 2'b00, 5'd13, 5, "R9 group top");
    do_wr(1'b0, 2'b00, 5'(COM), '{8'h8A}, "R9 set kind");
    do_rd(1'b0, 2'b00, 5'd4, 4, "R9 kind data");
    do_rd(1'b1, 2'b00, 5'd14, 4, "R9 kind config");
    do_wr(1'b0, 2'b00, 5'(COM), '{8'hC0}, "R9 set all");
    do_rd(1'b0, 2'b00, 5'd14, 4, "R1 R9 all");
    do_rd(1'b1, 2'b00, 5'd25, 3, "R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule